// File: doc/BRIEF.md
# Table-Based PID Current-Command Compensator

This block is the voltage-loop compensator of a digitally controlled current-mode regulator. Each time a new error code arrives it forms the next current command as the sum of three gain products: one from the present error, one from the error before it and one from the error two samples back. No multiplier is used. Each product comes from a small gain table held in flip-flops.

A table does not keep all fifteen signed products of its gain. It keeps five unsigned entries: the gain times 1, 2, 4, 5 and 8. Three subtractors rebuild the magnitudes 3, 6 and 7 from those entries. The rebuilt value is then negated when the error is negative. Software or a sequencer fills the tables through a small write port before the loop is closed. The command that is produced is used in the following switching cycle.

Top module: `lut_pid_comp`

## Requirements
- R1: An error code is 4 bits. Bit 3 is the sign (1 = negative) and bits 2:0 are the magnitude. The code 4'b1000 acts as zero.
- R2: Each table has five slots: 0 = gain×1, 1 = gain×2, 2 = gain×4, 3 = gain×5, 4 = gain×8. The product for each magnitude is: 0 gives 0; 1 gives slot0; 2 gives slot1; 3 gives slot2−slot0; 4 gives slot2; 5 gives slot3; 6 gives slot4−slot1; 7 gives slot4−slot0.
- R3: When the sign bit is set, the table product is negated.
- R4: On a valid error, the command is P_A(e[n]) + P_B(e[n−1]) + P_C(e[n−2]). Here e[n−1] and e[n−2] are the two previous valid errors, and both are zero after reset.
- R5: `cmd_vld_o` is high exactly in the cycle after each cycle in which `err_vld_i` is high. In that cycle `cmd_o` holds the new command.
- R6: In a cycle without `err_vld_i`, the error history and `cmd_o` do not change.
- R7: After reset, `cmd_o` is 0, `cmd_vld_o` is 0, both history samples are zero and every table entry is zero.
- R8: A write with `wr_en_i` high stores `wr_data_i` into table `wr_tbl_i` (0 = A, 1 = B, 2 = C) at slot `wr_slot_i`. A table code of 3, or a slot above 4, changes no entry.
- R9: `cmd_o` is COEF_W+3 bits, two's complement. Any table contents and errors give the exact sum with no wrap, down to −3·(2^COEF_W−1) and up to +3·(2^COEF_W−1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Table write enable |
| wr_tbl_i | input | 2 | Table select for a write |
| wr_slot_i | input | 3 | Slot select for a write |
| wr_data_i | input | COEF_W | Unsigned entry to write |
| err_vld_i | input | 1 | Error sample strobe |
| err_i | input | 4 | Sign-magnitude error code |
| cmd_vld_o | output | 1 | Command strobe |
| cmd_o | output | COEF_W+3 | Signed current command |

## Verification
The assertions take for granted that table writes do not happen at the same time as error strobes. A write in the same cycle as a strobe would be legal, but the bound range check assumes the entries are in a settled state. The bench therefore performs every table load in cycles where `err_vld_i` is low. It keeps every write in its own cycle, including the writes that must be ignored. The random error phase drives only the write port's idle values and mixes strobed and idle cycles, so that the hold behaviour is observed between samples.

// File: rtl/lut_pid_pkg.sv
package lut_pid_pkg;
  localparam int ERR_W    = 4;
  localparam int MAG_W    = ERR_W - 1;
  localparam int NUM_TBL  = 3;
  localparam int NUM_SLOT = 5;
  localparam int TBL_SEL_W  = 2;
  localparam int SLOT_SEL_W = 3;

  typedef enum logic [SLOT_SEL_W-1:0] {
    SLOT_X1 = 3'd0,
    SLOT_X2 = 3'd1,
    SLOT_X4 = 3'd2,
    SLOT_X5 = 3'd3,
    SLOT_X8 = 3'd4
  } slot_e;
endpackage

// File: rtl/lut_pid_coef_bank.sv
module lut_pid_coef_bank
  import lut_pid_pkg::*;
#(
  parameter int COEF_W = 8,
  parameter int TBL_ID = 0
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 wr_en_i,
  input  logic [TBL_SEL_W-1:0]                 wr_tbl_i,
  input  logic [SLOT_SEL_W-1:0]                wr_slot_i,
  input  logic [COEF_W-1:0]                    wr_data_i,
  output logic [NUM_SLOT-1:0][COEF_W-1:0]      coef_o
);
  logic tbl_hit;
  assign tbl_hit = wr_en_i && (wr_tbl_i == TBL_SEL_W'(TBL_ID));

  for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
    logic [COEF_W-1:0] ent_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                         ent_q <= '0;
      else if (tbl_hit && wr_slot_i == SLOT_SEL_W'(s))     ent_q <= wr_data_i;
    end
    assign coef_o[s] = ent_q;
  end
endmodule

// File: rtl/lut_pid_rebuild.sv
module lut_pid_rebuild
  import lut_pid_pkg::*;
#(
  parameter int COEF_W = 8
) (
  input  logic [NUM_SLOT-1:0][COEF_W-1:0] coef_i,
  input  logic [ERR_W-1:0]                code_i,
  output logic signed [COEF_W:0]          prod_o
);
  logic signed [COEF_W:0] x1, x2, x4, x5, x8;
  logic signed [COEF_W:0] x3, x6, x7;
  logic signed [COEF_W:0] mag_prod;

  assign x1 = $signed({1'b0, coef_i[SLOT_X1]});
  assign x2 = $signed({1'b0, coef_i[SLOT_X2]});
  assign x4 = $signed({1'b0, coef_i[SLOT_X4]});
  assign x5 = $signed({1'b0, coef_i[SLOT_X5]});
  assign x8 = $signed({1'b0, coef_i[SLOT_X8]});

  // the three rebuild subtractors
  assign x3 = x4 - x1;
  assign x6 = x8 - x2;
  assign x7 = x8 - x1;

  always_comb begin
    unique case (code_i[MAG_W-1:0])
      3'd1:    mag_prod = x1;
      3'd2:    mag_prod = x2;
      3'd3:    mag_prod = x3;
      3'd4:    mag_prod = x4;
      3'd5:    mag_prod = x5;
      3'd6:    mag_prod = x6;
      3'd7:    mag_prod = x7;
      default: mag_prod = '0;
    endcase
  end

  assign prod_o = code_i[ERR_W-1] ? -mag_prod : mag_prod;
endmodule

// File: rtl/lut_pid_comp.sv
module lut_pid_comp
  import lut_pid_pkg::*;
#(
  parameter int COEF_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [1:0]              wr_tbl_i,
  input  logic [2:0]              wr_slot_i,
  input  logic [COEF_W-1:0]       wr_data_i,
  input  logic                    err_vld_i,
  input  logic [3:0]              err_i,
  output logic                    cmd_vld_o,
  output logic [COEF_W+2:0]       cmd_o
);
  localparam int PROD_W = COEF_W + 1;
  localparam int CMD_W  = COEF_W + 3;

  logic [ERR_W-1:0] err_d1_q, err_d2_q;
  logic [NUM_TBL-1:0][ERR_W-1:0] tap;
  logic signed [PROD_W-1:0] prod [NUM_TBL];
  logic signed [CMD_W-1:0]  sum;
  logic [CMD_W-1:0]         cmd_q;
  logic                     vld_q;

  assign tap[0] = err_i;
  assign tap[1] = err_d1_q;
  assign tap[2] = err_d2_q;

  for (genvar t = 0; t < NUM_TBL; t++) begin : g_tbl
    logic [NUM_SLOT-1:0][COEF_W-1:0] coef;
    lut_pid_coef_bank #(.COEF_W(COEF_W), .TBL_ID(t)) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en_i),
      .wr_tbl_i  (wr_tbl_i),
      .wr_slot_i (wr_slot_i),
      .wr_data_i (wr_data_i),
      .coef_o    (coef)
    );
    lut_pid_rebuild #(.COEF_W(COEF_W)) u_rebuild (
      .coef_i (coef),
      .code_i (tap[t]),
      .prod_o (prod[t])
    );
  end

  assign sum = {{2{prod[0][PROD_W-1]}}, prod[0]}
             + {{2{prod[1][PROD_W-1]}}, prod[1]}
             + {{2{prod[2][PROD_W-1]}}, prod[2]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_d1_q <= '0;
      err_d2_q <= '0;
      cmd_q    <= '0;
      vld_q    <= 1'b0;
    end else begin
      vld_q <= err_vld_i;
      if (err_vld_i) begin
        cmd_q    <= sum;
        err_d1_q <= err_i;
        err_d2_q <= err_d1_q;
      end
    end
  end

  assign cmd_o     = cmd_q;
  assign cmd_vld_o = vld_q;
endmodule

// File: rtl/lut_pid_comp_chk.sv
module lut_pid_comp_chk #(
  parameter int COEF_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              err_vld_i,
  input logic [3:0]        err_i,
  input logic              cmd_vld_o,
  input logic [COEF_W+2:0] cmd_o,
  input logic [3:0]        hist1_i,
  input logic [3:0]        hist2_i
);
  localparam int LIM = 3 * ((1 << COEF_W) - 1);

  p_vld_latency_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_vld_i |=> cmd_vld_o);

  p_no_vld_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_vld_i |=> !cmd_vld_o);

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_vld_i |=> ($stable(cmd_o) && $stable(hist1_i) && $stable(hist2_i)));

  p_zero_err_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_vld_i && err_i[2:0] == 3'd0 && hist1_i[2:0] == 3'd0 && hist2_i[2:0] == 3'd0)
    |=> (cmd_o == '0));

  p_no_overflow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($signed(cmd_o) <= LIM) && ($signed(cmd_o) >= -LIM));
endmodule

bind lut_pid_comp lut_pid_comp_chk #(.COEF_W(COEF_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .err_vld_i (err_vld_i),
  .err_i     (err_i),
  .cmd_vld_o (cmd_vld_o),
  .cmd_o     (cmd_o),
  .hist1_i   (err_d1_q),
  .hist2_i   (err_d2_q)
);

// File: tb/sim_lut_pid_comp.sv
`timescale 1ns/1ps
module sim_lut_pid_comp;
  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           wr_en = 1'b0;
  logic [1:0]     wr_tbl = '0;
  logic [2:0]     wr_slot = '0;
  logic [W-1:0]   wr_data = '0;
  logic           err_vld = 1'b0;
  logic [3:0]     err = '0;
  logic           cmd_vld;
  logic [W+2:0]   cmd;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  string tag = "R4";

  int tbl [3][5];
  int h1 = 0, h2 = 0;   // history as integer error values
  int exp_cmd = 0;
  bit exp_vld = 1'b0;

  always #2 clk = ~clk;

  lut_pid_comp #(.COEF_W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_tbl_i(wr_tbl),
    .wr_slot_i(wr_slot), .wr_data_i(wr_data), .err_vld_i(err_vld),
    .err_i(err), .cmd_vld_o(cmd_vld), .cmd_o(cmd)
  );

  function automatic int code_val(input logic [3:0] c);
    return c[3] ? -int'(c[2:0]) : int'(c[2:0]);
  endfunction

  function automatic int tbl_prod(input int t, input int v);
    int m, p;
    m = (v < 0) ? -v : v;
    case (m)
      1: p = tbl[t][0];
      2: p = tbl[t][1];
      3: p = tbl[t][2] - tbl[t][0];
      4: p = tbl[t][2];
      5: p = tbl[t][3];
      6: p = tbl[t][4] - tbl[t][1];
      7: p = tbl[t][4] - tbl[t][0];
      default: p = 0;
    endcase
    return (v < 0) ? -p : p;
  endfunction

  task automatic check(input string rq, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", rq, act, expv, $time);
    end
  endtask

  // reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      h1 = 0; h2 = 0; exp_cmd = 0; exp_vld = 0;
      for (int t = 0; t < 3; t++) for (int s = 0; s < 5; s++) tbl[t][s] = 0;
    end else begin
      exp_vld = err_vld;
      if (err_vld) begin
        exp_cmd = tbl_prod(0, code_val(err)) + tbl_prod(1, h1) + tbl_prod(2, h2);
        h2 = h1;
        h1 = code_val(err);
      end
      if (wr_en && wr_tbl < 3 && wr_slot < 5) tbl[wr_tbl][wr_slot] = int'(wr_data);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R5", int'(cmd_vld), int'(exp_vld));
      check(exp_vld ? tag : {tag, " R6"}, $signed(cmd), exp_cmd);
    end
  end

  task automatic wr(input int t, input int s, input int d);
    @(negedge clk);
    wr_en = 1; wr_tbl = 2'(t); wr_slot = 3'(s); wr_data = W'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic load_gain(input int t, input int g);
    wr(t, 0, g); wr(t, 1, 2*g); wr(t, 2, 4*g); wr(t, 3, 5*g); wr(t, 4, 8*g);
  endtask

  task automatic step(input bit v, input logic [3:0] e);
    @(negedge clk);
    err_vld = v; err = e;
    @(negedge clk);
    err_vld = 0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int lf;
    repeat (3) @(negedge clk);
    // R7: reset state
    check("R7", int'(cmd_vld), 0);
    check("R7", int'(cmd), 0);
    rst_n = 1;
    tag = "R7";
    step(1, 4'b0101); step(1, 4'b1111); step(1, 4'b0011); // zero tables
    tag = "R2 R4";
    load_gain(0, 5); load_gain(1, 3); load_gain(2, 1);
    for (int c = 0; c < 16; c++) step(1, 4'(c));
    tag = "R1 R3";
    step(1, 4'b1000); step(1, 4'b1000); step(1, 4'b1000);
    step(1, 4'b1111); step(1, 4'b0111); step(1, 4'b1001);
    tag = "R6";
    step(0, 4'b0111); step(1, 4'b0010); step(0, 4'b1111); step(0, 4'b0001);
    step(1, 4'b0110);
    tag = "R8";
    wr(3, 0, 200); wr(0, 5, 200); wr(1, 7, 200); wr(3, 4, 99);
    for (int c = 1; c < 8; c++) step(1, 4'(c));
    // inconsistent entries exercise rebuild differently
    tag = "R2";
    wr(0, 0, 17); wr(0, 3, 250); wr(1, 4, 9); wr(2, 1, 77);
    for (int c = 0; c < 16; c++) step(1, 4'(15 - c));
    tag = "R9";
    for (int t = 0; t < 3; t++) begin
      wr(t, 0, 0); wr(t, 1, 255); wr(t, 2, 255); wr(t, 3, 255); wr(t, 4, 255);
    end
    step(1, 4'b1111); step(1, 4'b1111); step(1, 4'b1111);
    step(1, 4'b0111); step(1, 4'b0111); step(1, 4'b0111);
    for (int t = 0; t < 3; t++) begin wr(t, 0, 255); wr(t, 4, 0); end
    step(1, 4'b0111); step(1, 4'b0111); step(1, 4'b0111);
    step(1, 4'b1111); step(1, 4'b1111); step(1, 4'b1111);
    tag = "R4 R6";
    load_gain(0, 11); load_gain(1, 7); load_gain(2, 2);
    lf = 32'h1d3;
    for (int i = 0; i < 300; i++) begin
      lf = (lf >> 1) ^ ((lf & 1) ? 32'h2d1 : 0);
      @(negedge clk);
      err_vld = lf[0] | lf[5];
      err = 4'(lf >> 2);
    end
    @(negedge clk); err_vld = 0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule